// File: doc/BRIEF.md
# Staged Power-Switch Turn-On Sequencer

This block drives the header switches of one power-gated domain, along with the isolation clamp and the reset that surround it. The switches sit in a set of groups of growing size. A power-up request enables the groups one at a time, and each group waits for its own programmed cycle delay. Bringing the switches on in small steps limits inrush current and supply droop. When the largest group is on, the block waits a programmed settle time, then releases isolation, then reset, and then raises a ready flag.

A power-down request reverses the order. Reset is asserted first, then isolation is asserted, and then the groups are shed one per cycle, starting with the largest. A wake interrupt starts power-up in the same way as a software up request. A request that arrives while a sequence is running is held and acted on once the block is back in a stable state. A 3-bit status output reports the current phase.

Top module: `rail_stager`

## Requirements
- R1: While reset is held and in the first cycle after it, all group enables are 0, `iso_on` is 1, `dom_rst_n` is 0, `ready` is 0 and `state_o` is 0.
- R2: An `up_req` pulse sampled at clock edge P, with the block off, moves `state_o` to 1 (ramping) at edge P+1.
- R3: Group 0 turns on at edge P+d0+2, where dk is field k of `dly_grp` (bits k*CNT_W upward). Group k+1 turns on dk+1 + 1 edges after group k.
- R4: The group enables always form a thermometer code (group k+1 on implies group k on), and at most one enable changes per cycle.
- R5: `iso_on` falls `dly_iso`+1 edges after the last group turns on, and is low only while every group is on. `state_o` is 2 while waiting for this.
- R6: `dom_rst_n` rises one edge after isolation is released (state 3). At that same edge `state_o` becomes 4. `ready` rises one edge later, and is high only while `dom_rst_n` is high.
- R7: A `down_req` pulse sampled at edge P, with the block on, gives the following sequence:
  - at P+1: `dom_rst_n` and `ready` fall, and `state_o` is 5;
  - at P+2: `iso_on` rises, and `state_o` is 6;
  - from P+3: one group turns off per edge, highest index first;
  - at P+N_GROUPS+2: `state_o` is 0.
- R8: A request that arrives mid-sequence is held until the sequence ends, and then runs. Of an up request and a down request, the later one wins. If both arrive together, up wins.
- R9: An up request while on, or a down request while off, changes no output and is discarded.
- R10: A `wake_irq` pulse has exactly the effect of an `up_req` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_req | input | 1 | Power-up request pulse |
| down_req | input | 1 | Power-down request pulse |
| wake_irq | input | 1 | Wake interrupt pulse, acts as a power-up request |
| dly_grp | input | N_GROUPS*CNT_W | Per-group delay in cycles, field k for group k |
| dly_iso | input | CNT_W | Settle delay between the last group and isolation release |
| grp_en | output | N_GROUPS | Switch group enables, bit 0 smallest group |
| iso_on | output | 1 | Isolation clamp active |
| dom_rst_n | output | 1 | Domain reset, active low |
| ready | output | 1 | Domain powered and out of reset |
| state_o | output | 3 | Phase: 0 off, 1 ramp, 2 iso wait, 3 reset release, 4 on, 5 iso set, 6 shed |

## Verification
The bench builds the block with four groups and 4-bit delay fields. It sweeps every combination of group delays from 0 to 2 against settle delays of 0 and 3. This covers zero-length stages, back-to-back enables and unequal spacing, and each edge time is compared against the arithmetic sum of the delays. With delay fields this narrow, the bench can also exercise the held-request cases, which need a request to land inside a ramp or inside a shed. It covers the discarded-request cases in the same way.

// File: rtl/rs_pkg.sv
// Shared phase encoding for the staged power-switch sequencer.
package rs_pkg;
    typedef enum logic [2:0] {
        ST_OFF      = 3'd0,
        ST_RAMP     = 3'd1,
        ST_ISO_WAIT = 3'd2,
        ST_RST_REL  = 3'd3,
        ST_ON       = 3'd4,
        ST_ISO_SET  = 3'd5,
        ST_SHED     = 3'd6
    } rs_state_t;
endpackage

// File: rtl/rs_req_hold.sv
// Holds pending up/down requests until the controller consumes them.
// Assumes request inputs are single-cycle pulses; a newer request
// replaces an opposite pending one, and up wins on a tie.
module rs_req_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic up_set,
    input  logic dn_set,
    input  logic up_clr,
    input  logic dn_clr,
    output logic up_pend,
    output logic dn_pend
);
    // Latch requests; a fresh set beats a consume in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_pend <= 1'b0;
            dn_pend <= 1'b0;
        end else if (up_set) begin
            up_pend <= 1'b1;
            dn_pend <= 1'b0;
        end else if (dn_set) begin
            dn_pend <= 1'b1;
            up_pend <= 1'b0;
        end else begin
            if (up_clr) up_pend <= 1'b0;
            if (dn_clr) dn_pend <= 1'b0;
        end
    end
endmodule

// File: rtl/rs_countdown.sv
// Shared stage delay counter: loads a value and counts down to zero.
// Assumes load has priority over counting.
module rs_countdown #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    // Load or decrement toward zero, then hold.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/rs_ctrl.sv
// Phase controller: walks group enables up with programmed delays,
// releases isolation then reset, and reverses on power-down.
// Assumes N_GROUPS >= 2; select value N_GROUPS picks the settle delay.
module rs_ctrl
    import rs_pkg::*;
#(
    parameter int N_GROUPS = 4,
    parameter int IDX_W    = $clog2(N_GROUPS),
    parameter int SEL_W    = $clog2(N_GROUPS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_pend,
    input  logic             dn_pend,
    input  logic             cnt_zero,
    output logic             up_clr,
    output logic             dn_clr,
    output logic             load,
    output logic [SEL_W-1:0] load_sel,
    output logic             grp_set,
    output logic             grp_clr,
    output logic [IDX_W-1:0] grp_idx,
    output logic             iso_on,
    output logic             dom_rst_n,
    output logic             ready,
    output logic [2:0]       state_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_GROUPS - 1);

    rs_state_t        st_q;
    logic [IDX_W-1:0] idx_q;

    // Per-phase strobes to the counter, request holder and group flops.
    always_comb begin
        up_clr   = 1'b0;
        dn_clr   = 1'b0;
        load     = 1'b0;
        load_sel = '0;
        grp_set  = 1'b0;
        grp_clr  = 1'b0;
        case (st_q)
            ST_OFF: begin
                if (up_pend) begin
                    up_clr = 1'b1;
                    load   = 1'b1;
                end else if (dn_pend) begin
                    dn_clr = 1'b1;
                end
            end
            ST_RAMP: begin
                if (cnt_zero) begin
                    grp_set  = 1'b1;
                    load     = 1'b1;
                    load_sel = (idx_q == LAST) ? SEL_W'(N_GROUPS)
                                               : SEL_W'(idx_q) + SEL_W'(1);
                end
            end
            ST_ON: begin
                if (dn_pend)      dn_clr = 1'b1;
                else if (up_pend) up_clr = 1'b1;
            end
            ST_SHED: grp_clr = 1'b1;
            default: ;
        endcase
    end

    // Phase register, group index, isolation, reset and ready flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_OFF;
            idx_q     <= '0;
            iso_on    <= 1'b1;
            dom_rst_n <= 1'b0;
            ready     <= 1'b0;
        end else begin
            case (st_q)
                ST_OFF: if (up_pend) begin
                    st_q  <= ST_RAMP;
                    idx_q <= '0;
                end
                ST_RAMP: if (cnt_zero) begin
                    if (idx_q == LAST) st_q  <= ST_ISO_WAIT;
                    else               idx_q <= idx_q + 1'b1;
                end
                ST_ISO_WAIT: if (cnt_zero) begin
                    iso_on <= 1'b0;
                    st_q   <= ST_RST_REL;
                end
                ST_RST_REL: begin
                    dom_rst_n <= 1'b1;
                    st_q      <= ST_ON;
                end
                ST_ON: begin
                    if (dn_pend) begin
                        dom_rst_n <= 1'b0;
                        ready     <= 1'b0;
                        st_q      <= ST_ISO_SET;
                    end else begin
                        ready <= 1'b1;
                    end
                end
                ST_ISO_SET: begin
                    iso_on <= 1'b1;
                    idx_q  <= LAST;
                    st_q   <= ST_SHED;
                end
                ST_SHED: begin
                    if (idx_q == '0) st_q  <= ST_OFF;
                    else             idx_q <= idx_q - 1'b1;
                end
                default: st_q <= ST_OFF;
            endcase
        end
    end

    assign grp_idx = idx_q;
    assign state_o = st_q;
endmodule

// File: rtl/rail_stager.sv
// Top of the staged power-switch sequencer. Wires the request holder,
// shared delay counter and phase controller, selects the active delay
// and keeps one enable flop per switch group.
// Assumes request inputs are synchronous single-cycle pulses and the
// delay inputs are stable while a sequence runs.
module rail_stager #(
    parameter int N_GROUPS = 4,
    parameter int CNT_W    = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      up_req,
    input  logic                      down_req,
    input  logic                      wake_irq,
    input  logic [N_GROUPS*CNT_W-1:0] dly_grp,
    input  logic [CNT_W-1:0]          dly_iso,
    output logic [N_GROUPS-1:0]       grp_en,
    output logic                      iso_on,
    output logic                      dom_rst_n,
    output logic                      ready,
    output logic [2:0]                state_o
);
    localparam int IDX_W = $clog2(N_GROUPS);
    localparam int SEL_W = $clog2(N_GROUPS + 1);
    localparam int N_SEL = 1 << SEL_W;

    logic             up_pend, dn_pend, up_clr, dn_clr;
    logic             load, cnt_zero, grp_set, grp_clr;
    logic [SEL_W-1:0] load_sel;
    logic [IDX_W-1:0] grp_idx;
    logic [CNT_W-1:0] dly_tab [N_SEL];

    rs_req_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .up_set  (up_req | wake_irq),
        .dn_set  (down_req),
        .up_clr  (up_clr),
        .dn_clr  (dn_clr),
        .up_pend (up_pend),
        .dn_pend (dn_pend)
    );

    // Delay table: one entry per group, remaining entries the settle delay.
    for (genvar g = 0; g < N_SEL; g++) begin : g_tab
        if (g < N_GROUPS) begin : g_grp
            assign dly_tab[g] = dly_grp[g*CNT_W +: CNT_W];
        end else begin : g_iso
            assign dly_tab[g] = dly_iso;
        end
    end

    rs_countdown #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (dly_tab[load_sel]),
        .zero     (cnt_zero)
    );

    rs_ctrl #(.N_GROUPS(N_GROUPS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .up_pend   (up_pend),
        .dn_pend   (dn_pend),
        .cnt_zero  (cnt_zero),
        .up_clr    (up_clr),
        .dn_clr    (dn_clr),
        .load      (load),
        .load_sel  (load_sel),
        .grp_set   (grp_set),
        .grp_clr   (grp_clr),
        .grp_idx   (grp_idx),
        .iso_on    (iso_on),
        .dom_rst_n (dom_rst_n),
        .ready     (ready),
        .state_o   (state_o)
    );

    // One enable flop per group, set and cleared by the indexed strobe.
    for (genvar k = 0; k < N_GROUPS; k++) begin : g_en
        always_ff @(posedge clk) begin
            if (!rst_n)                                   grp_en[k] <= 1'b0;
            else if (grp_set && grp_idx == IDX_W'(k))     grp_en[k] <= 1'b1;
            else if (grp_clr && grp_idx == IDX_W'(k))     grp_en[k] <= 1'b0;
        end
    end
endmodule

// File: rtl/rs_checks.sv
// Ordering properties of the sequencer outputs, bound to rail_stager.
module rs_checks #(
    parameter int N_GROUPS = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [N_GROUPS-1:0] grp_en,
    input logic                iso_on,
    input logic                dom_rst_n,
    input logic                ready
);
    assert_grp_thermo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_en & (grp_en + 1'b1)) == '0);

    assert_grp_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grp_en ^ $past(grp_en)) <= 1);

    assert_iso_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !iso_on |-> (&grp_en));

    assert_rst_after_iso_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dom_rst_n |-> !iso_on);

    assert_ready_rst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> dom_rst_n);

    assert_iso_before_shed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(iso_on) |-> (!dom_rst_n && !ready && (&grp_en)));
endmodule

bind rail_stager rs_checks #(.N_GROUPS(N_GROUPS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .grp_en    (grp_en),
    .iso_on    (iso_on),
    .dom_rst_n (dom_rst_n),
    .ready     (ready)
);

// File: tb/tb_rail_stager.sv
module tb_rail_stager;
    localparam int CLK_PERIOD = 10;
    localparam int NG = 4;
    localparam int W  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          up_req = 1'b0, down_req = 1'b0, wake_irq = 1'b0;
    logic [NG*W-1:0] dly_grp = '0;
    logic [W-1:0]  dly_iso = '0;
    logic [NG-1:0] grp_en;
    logic          iso_on, dom_rst_n, ready;
    logic [2:0]    state_o;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rail_stager #(.N_GROUPS(NG), .CNT_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .up_req(up_req), .down_req(down_req),
        .wake_irq(wake_irq), .dly_grp(dly_grp), .dly_iso(dly_iso),
        .grp_en(grp_en), .iso_on(iso_on), .dom_rst_n(dom_rst_n),
        .ready(ready), .state_o(state_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int snap();
        return {grp_en, iso_on, dom_rst_n, ready, state_o};
    endfunction

    // Pulse a request so that it is sampled at the next edge (edge P).
    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) up_req = 1'b1;
        else if (which == 1) wake_irq = 1'b1;
        else down_req = 1'b1;
        @(negedge clk);
        up_req = 1'b0; wake_irq = 1'b0; down_req = 1'b0;
    endtask

    // Power up with given delays; optionally inject a down request at negedge m=inj.
    task automatic run_up(input int d0, d1, d2, d3, di, input bit wake, input int inj);
        int d[4];
        int eg[4];
        int fg[4];
        int fi, fr, fy, iso_t, last_m;
        d = '{d0, d1, d2, d3};
        dly_grp = {W'(d3), W'(d2), W'(d1), W'(d0)};
        dly_iso = W'(di);
        eg[0] = d0 + 2;
        for (int k = 1; k < 4; k++) eg[k] = eg[k-1] + d[k] + 1;
        iso_t = eg[3] + di + 1;
        fg = '{-1, -1, -1, -1};
        fi = -1; fr = -1; fy = -1;
        last_m = (inj > 0) ? iso_t + 8 : iso_t + 3;
        pulse(wake ? 1 : 0);
        for (int m = 1; m <= last_m; m++) begin
            if (m == inj) down_req = 1'b1; else down_req = 1'b0;
            @(negedge clk);
            if (m == 1) chk(wake ? "R10 state after wake" : "R2 state after request", state_o, 1);
            for (int k = 0; k < 4; k++) if (grp_en[k] && fg[k] < 0) fg[k] = m;
            if (!iso_on && fi < 0) fi = m;
            if (dom_rst_n && fr < 0) fr = m;
            if (ready && fy < 0) fy = m;
            if (m == eg[3]) chk("R5 state waiting iso", state_o, 2);
        end
        down_req = 1'b0;
        for (int k = 0; k < 4; k++) chk($sformatf("R3 group %0d rise", k), fg[k], eg[k]);
        chk("R5 iso release", fi, iso_t);
        chk("R6 reset release", fr, iso_t + 1);
        if (inj > 0) begin
            chk("R8 ready suppressed by held down", fy, -1);
            chk("R8 held down reaches off", snap(), {4'b0000, 1'b1, 1'b0, 1'b0, 3'd0});
        end else begin
            chk("R6 ready rise", fy, iso_t + 2);
            chk("R6 on state", state_o, 4);
        end
    endtask

    task automatic run_down();
        int exp;
        pulse(2);
        for (int m = 1; m <= 6; m++) begin
            @(negedge clk);
            case (m)
                1: exp = {4'b1111, 1'b0, 1'b0, 1'b0, 3'd5};
                2: exp = {4'b1111, 1'b1, 1'b0, 1'b0, 3'd6};
                default: exp = {4'(4'b1111 >> (m - 2)), 1'b1, 1'b0, 1'b0,
                                (m == 6) ? 3'd0 : 3'd6};
            endcase
            chk($sformatf("R7 down step %0d", m), snap(), exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset held", snap(), {4'b0000, 1'b1, 1'b0, 1'b0, 3'd0});
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", snap(), {4'b0000, 1'b1, 1'b0, 1'b0, 3'd0});

        // Sweep all small delay combinations (R3, R5, R6, R7).
        for (int di = 0; di <= 3; di += 3)
            for (int a = 0; a < 3; a++)
                for (int b = 0; b < 3; b++)
                    for (int c = 0; c < 3; c++)
                        for (int e = 0; e < 3; e++) begin
                            run_up(a, b, c, e, di, 1'b0, 0);
                            run_down();
                        end

        // R10: wake interrupt behaves as up request.
        run_up(2, 0, 1, 2, 1, 1'b1, 0);

        // R9: up while on is ignored.
        pulse(0);
        repeat (4) @(negedge clk);
        chk("R9 up while on ignored", snap(), {4'b1111, 1'b0, 1'b1, 1'b1, 3'd4});
        run_down();
        repeat (6) @(negedge clk);
        chk("R9 no re-up after down", snap(), {4'b0000, 1'b1, 1'b0, 1'b0, 3'd0});

        // R9: down while off is ignored; following up still normal.
        pulse(2);
        repeat (4) @(negedge clk);
        chk("R9 down while off ignored", snap(), {4'b0000, 1'b1, 1'b0, 1'b0, 3'd0});
        run_up(1, 1, 1, 1, 1, 1'b0, 0);

        // R8: down during shed... first down then up held across the shed.
        begin
            int g0;
            g0 = -1;
            pulse(2);
            for (int m = 1; m <= 12; m++) begin
                if (m == 1) up_req = 1'b1; else up_req = 1'b0;
                @(negedge clk);
                if (m == 6) chk("R8 shed completes first", state_o, 0);
                if (grp_en[0] && g0 < 0 && m > 6) g0 = m;
            end
            chk("R8 held up group0 rise", g0, 1 + 8);
            repeat (20) @(negedge clk);
            chk("R8 held up reaches on", snap(), {4'b1111, 1'b0, 1'b1, 1'b1, 3'd4});
            run_down();
        end

        // R8: down request held during a ramp.
        run_up(1, 1, 1, 1, 1, 1'b0, 3);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule